// File: doc/BRIEF.md
# Bitplane Video Shifter with Colour Lookup

This block turns interleaved bitplane words from display memory into pixels. Depending on the active shift mode, it gathers four, two or one 16-bit words into a group. Each word belongs to one plane, and plane 0 arrives first. When the serialiser has run dry, the block moves the group into per-plane shift registers. It then emits one pixel per pixel-clock enable, taking the most significant bit first. The plane bits form a colour index, with plane 0 as the least significant bit. In the colour modes that index selects one of sixteen 9-bit palette entries, which drive 3-bit red, green and blue outputs. In the single-plane mode the palette is bypassed and a one-bit monochrome output is driven. Bit 0 of entry 0 inverts that output.

A CPU register port writes the palette entries and the shift-mode register. A written mode is held pending and only becomes active while display enable is low, so the picture never changes format in mid-line. While display enable is low the outputs show the border: palette entry 0 in the colour modes, black in monochrome.

The word collector is a two-state machine. FILL accepts load strobes and advances the plane slot. The transition FILL→HOLD fires when the last slot for the mode is written. The transition HOLD→FILL fires when the serialiser takes the group. An activation of a different mode forces FILL with slot 0. The serialiser has the states IDLE (no bits left) and RUN (bits left). The transition IDLE→RUN happens when a displayed pixel finds a complete group. The transition RUN→IDLE happens after the sixteenth pixel, or on any enabled pixel with display enable low.

Top module: `vshf_top`

## Requirements
- R1: After reset, the shift mode is 4-plane, every palette entry is zero, the collector is in FILL at slot 0, and red, green, blue and mono are all 0.
- R2: Register address 0–15 selects a palette entry. A write stores red from data bits [10:8], green from [6:4] and blue from [2:0]; the other data bits are ignored. Address 16 is the shift-mode register, using data bits [1:0].
- R3: In mode 0 (4-plane), four successive load strobes fill planes 0, 1, 2 and 3. The sixteen pixels of the group use bit 15 down to bit 0. Each index is {p3,p2,p1,p0}, and each pixel shows that palette entry.
- R4: In mode 1 (2-plane), two load strobes fill planes 0 and 1. The index is {0,0,p1,p0}, so only entries 0–3 are reached.
- R5: In mode 2 (1-plane), one strobe fills plane 0. Red, green and blue are 0, and mono equals the plane bit XOR bit 0 of palette entry 0.
- R6: On an enabled pixel with display enable low, the outputs show the border: entry 0 with mono 0 in modes 0 and 1, and all zero in mode 2.
- R7: A written mode becomes active only on a cycle with display enable low. A write of mode value 3 is ignored.
- R8: When a different mode becomes active, any partly collected group is discarded and collection restarts at plane 0.
- R9: A displayed pixel with no bits left and no complete group is shown with index 0.
- R10: While pixel enable is low, the outputs and the position in the group hold.
- R11: Load strobes that arrive while a complete group waits in HOLD are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: 0–15 palette, 16 shift mode |
| reg_wdata | input | 16 | Register write data |
| word_ld | input | 1 | Load strobe for one plane word |
| word_in | input | 16 | Plane word from display memory |
| pix_en | input | 1 | Pixel-clock enable |
| disp_en | input | 1 | Display enable; low means border or blanking |
| red | output | 3 | Red intensity |
| grn | output | 3 | Green intensity |
| blu | output | 3 | Blue intensity |
| mono | output | 1 | Monochrome pixel |

## Verification
The bench writes palette values with all unused data bits set to one. A decoder that reads the wrong field therefore shows up in the border colour and in every pixel. A mode written while the display is active must not disturb the running group. A reserved mode write must leave 2-plane behaviour intact; a design that took it would wait forever for four words and show starved pixels. A half-filled group left over from a mode switch would rotate the plane slots, and monochrome pixels would then come from the wrong word. The bench also checks that pixels run dry to entry 0, that a pause in pixel enable neither skips nor repeats a pixel, and that a surplus strobe cannot overwrite plane 0 of a waiting group.

// File: rtl/vshf_pkg.sv
package vshf_pkg;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        MODE_LO4  = 2'b00,
        MODE_MED2 = 2'b01,
        MODE_HI1  = 2'b10,
        MODE_RSVD = 2'b11
    } shmode_t;

    typedef enum logic { COL_FILL, COL_HOLD } col_state_t;
    typedef enum logic { SER_IDLE, SER_RUN } ser_state_t;

    typedef struct packed {
        logic [2:0] r;
        logic [2:0] g;
        logic [2:0] b;
    } rgb_t;
endpackage

// File: rtl/shf_regs.sv
module shf_regs
    import vshf_pkg::*;
#(
    parameter int NPL = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [NPL:0]            reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    input  logic                    disp_en,
    output rgb_t [(2**NPL)-1:0]     pal,
    output shmode_t                 mode_act,
    output logic                    mode_upd
);
    localparam int PAL_N = 2 ** NPL;
    localparam int AW    = NPL + 1;

    shmode_t mode_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal      <= '0;
            mode_req <= MODE_LO4;
            mode_act <= MODE_LO4;
        end else begin
            if (reg_we && !reg_addr[NPL])
                pal[reg_addr[NPL-1:0]] <= '{r: reg_wdata[10:8],
                                            g: reg_wdata[6:4],
                                            b: reg_wdata[2:0]};
            if (reg_we && reg_addr == AW'(PAL_N) && reg_wdata[1:0] != 2'b11)
                mode_req <= shmode_t'(reg_wdata[1:0]);
            if (!disp_en)
                mode_act <= mode_req;
        end
    end

    assign mode_upd = !disp_en && (mode_req != mode_act);

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |=> $stable(mode_act)); // R7
    AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_act != MODE_RSVD); // R7
endmodule

// File: rtl/shf_collect.sv
module shf_collect
    import vshf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NPL    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_ld,
    input  logic [WORD_W-1:0]             word_in,
    input  shmode_t                       mode_act,
    input  logic                          mode_upd,
    input  logic                          grp_take,
    output logic                          grp_ready,
    output logic [NPL-1:0][WORD_W-1:0]    grp_words
);
    localparam int IW = $clog2(NPL) + 1;

    col_state_t state_q, state_d;
    logic [IW-1:0] widx;
    logic [IW-1:0] nplanes;
    logic          last_slot;

    always_comb begin
        unique case (mode_act)
            MODE_MED2: nplanes = IW'(NPL / 2);
            MODE_HI1:  nplanes = IW'(1);
            default:   nplanes = IW'(NPL);
        endcase
    end

    assign last_slot = (widx == nplanes - IW'(1));

    always_comb begin
        state_d = state_q;
        if (mode_upd) begin
            state_d = COL_FILL;
        end else begin
            unique case (state_q)
                COL_FILL: if (word_ld && last_slot) state_d = COL_HOLD;
                COL_HOLD: if (grp_take)             state_d = COL_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= COL_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx      <= '0;
            grp_words <= '0;
        end else if (mode_upd) begin
            widx <= '0;
        end else if (state_q == COL_FILL && word_ld) begin
            grp_words[widx[IW-2:0]] <= word_in;
            widx <= last_slot ? '0 : widx + IW'(1);
        end
    end

    assign grp_ready = (state_q == COL_HOLD);

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        widx < nplanes); // R3
    AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == COL_HOLD && !grp_take && !mode_upd) |=> $stable(grp_words)); // R11
endmodule

// File: rtl/shf_serial.sv
module shf_serial
    import vshf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NPL    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pix_en,
    input  logic                          disp_en,
    input  logic                          grp_ready,
    input  logic [NPL-1:0][WORD_W-1:0]    grp_words,
    output logic                          grp_take,
    output logic [NPL-1:0]                pix_bits
);
    localparam int CW = $clog2(WORD_W);

    ser_state_t state_q;
    logic [CW-1:0] cnt;
    logic [NPL-1:0][WORD_W-1:0] sh;

    assign grp_take = pix_en && disp_en && (state_q == SER_IDLE) && grp_ready;

    for (genvar p = 0; p < NPL; p++) begin : g_bit
        assign pix_bits[p] = (state_q == SER_RUN) ? sh[p][WORD_W-1] :
                             grp_take             ? grp_words[p][WORD_W-1] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            cnt     <= '0;
            sh      <= '0;
        end else if (pix_en) begin
            if (!disp_en) begin
                state_q <= SER_IDLE;
                cnt     <= '0;
            end else begin
                unique case (state_q)
                    SER_RUN: begin
                        for (int p = 0; p < NPL; p++)
                            sh[p] <= {sh[p][WORD_W-2:0], 1'b0};
                        cnt <= cnt - CW'(1);
                        if (cnt == CW'(1)) state_q <= SER_IDLE;
                    end
                    SER_IDLE: begin
                        if (grp_take) begin
                            for (int p = 0; p < NPL; p++)
                                sh[p] <= {grp_words[p][WORD_W-2:0], 1'b0};
                            cnt     <= CW'(WORD_W - 1);
                            state_q <= SER_RUN;
                        end
                    end
                endcase
            end
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_RUN) |-> (cnt != '0)); // R3
    AST_PAUSE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(cnt)); // R10
endmodule

// File: rtl/shf_colour.sv
module shf_colour
    import vshf_pkg::*;
#(
    parameter int NPL = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_en,
    input  logic                    disp_en,
    input  shmode_t                 mode_act,
    input  rgb_t [(2**NPL)-1:0]     pal,
    input  logic [NPL-1:0]          pix_bits,
    output rgb_t                    rgb_q,
    output logic                    mono_q
);
    logic [NPL-1:0] mask;
    logic [NPL-1:0] idx;
    rgb_t rgb_d;
    logic mono_d;

    always_comb begin
        mask = '0;
        unique case (mode_act)
            MODE_MED2: mask[NPL/2-1:0] = '1;
            MODE_HI1:  mask[0] = 1'b1;
            default:   mask = '1;
        endcase
        idx = pix_bits & mask;
    end

    always_comb begin
        rgb_d  = '0;
        mono_d = 1'b0;
        if (!disp_en) begin
            if (mode_act != MODE_HI1) rgb_d = pal[0];
        end else if (mode_act == MODE_HI1) begin
            mono_d = idx[0] ^ pal[0].b[0];
        end else begin
            rgb_d = pal[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_q  <= '0;
            mono_q <= 1'b0;
        end else if (pix_en) begin
            rgb_q  <= rgb_d;
            mono_q <= mono_d;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable({rgb_q, mono_q})); // R10
    AST_BORDER_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !disp_en && mode_act != MODE_HI1) |=> (rgb_q == $past(pal[0]) && !mono_q)); // R6
    AST_MONO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && mode_act == MODE_HI1) |=> (rgb_q == '0)); // R5
endmodule

// File: rtl/vshf_top.sv
module vshf_top
    import vshf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NPL    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [NPL:0]      reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              word_ld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              pix_en,
    input  logic              disp_en,
    output logic [2:0]        red,
    output logic [2:0]        grn,
    output logic [2:0]        blu,
    output logic              mono
);
    localparam int PAL_N = 2 ** NPL;

    rgb_t [PAL_N-1:0]            pal;
    shmode_t                     mode_act;
    logic                        mode_upd;
    logic                        grp_ready;
    logic                        grp_take;
    logic [NPL-1:0][WORD_W-1:0]  grp_words;
    logic [NPL-1:0]              pix_bits;
    rgb_t                        rgb_q;

    shf_regs #(.NPL(NPL)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .disp_en(disp_en), .pal(pal),
        .mode_act(mode_act), .mode_upd(mode_upd)
    );

    shf_collect #(.WORD_W(WORD_W), .NPL(NPL)) u_collect (
        .clk(clk), .rst_n(rst_n), .word_ld(word_ld), .word_in(word_in),
        .mode_act(mode_act), .mode_upd(mode_upd), .grp_take(grp_take),
        .grp_ready(grp_ready), .grp_words(grp_words)
    );

    shf_serial #(.WORD_W(WORD_W), .NPL(NPL)) u_serial (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .disp_en(disp_en),
        .grp_ready(grp_ready), .grp_words(grp_words),
        .grp_take(grp_take), .pix_bits(pix_bits)
    );

    shf_colour #(.NPL(NPL)) u_colour (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .disp_en(disp_en),
        .mode_act(mode_act), .pal(pal), .pix_bits(pix_bits),
        .rgb_q(rgb_q), .mono_q(mono)
    );

    assign red = rgb_q.r;
    assign grn = rgb_q.g;
    assign blu = rgb_q.b;
endmodule

// File: tb/tb_vshf_top.sv
`timescale 1ns/1ps
module tb_vshf_top;
    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, word_ld = 1'b0;
    logic pix_en = 1'b1, disp_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, word_in = '0;
    logic [2:0]  red, grn, blu;
    logic        mono;

    always #2.5 clk = ~clk;

    vshf_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .word_ld(word_ld), .word_in(word_in),
        .pix_en(pix_en), .disp_en(disp_en), .red(red), .grn(grn),
        .blu(blu), .mono(mono)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [8:0]  pal_m [16];
    logic [1:0]  mode_m = 2'd0;
    logic [15:0] bw [4];
    logic [9:0]  first_o, last_o;

    // {w0,w1,w2,w3, leftmost index, rightmost index}
    localparam logic [71:0] TBL [4] = '{
        {16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 4'd1,  4'd1},
        {16'h8001, 16'h8000, 16'h0001, 16'h8000, 4'd11, 4'd5},
        {16'h00FF, 16'h0F0F, 16'h3333, 16'h5555, 4'd0,  4'd15},
        {16'hA5C3, 16'h5A3C, 16'hFF00, 16'h0F0F, 4'd5,  4'd9}
    };

    function automatic logic [9:0] model(logic [3:0] b);
        case (mode_m)
            2'd1:    return {pal_m[{2'b00, b[1:0]}], 1'b0};
            2'd2:    return {9'd0, b[0] ^ pal_m[0][0]};
            default: return {pal_m[b], 1'b0};
        endcase
    endfunction

    function automatic logic [9:0] border();
        return (mode_m == 2'd2) ? 10'd0 : {pal_m[0], 1'b0};
    endfunction

    function automatic logic [3:0] bits_at(int i);
        logic [3:0] t;
        for (int p = 0; p < 4; p++) t[p] = bw[p][15-i];
        return t;
    endfunction

    task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {red, grn, blu, mono};
    endfunction

    task automatic wreg(logic [4:0] a, logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic set_pal(int i, logic [8:0] v);
        pal_m[i] = v;
        wreg(5'(i), {5'b11111, v[8:6], 1'b1, v[5:3], 1'b1, v[2:0]});
    endtask

    task automatic load_word(logic [15:0] w);
        @(negedge clk); word_ld = 1'b1; word_in = w;
        @(negedge clk); word_ld = 1'b0;
    endtask

    task automatic load_group(int nw, logic [15:0] a, logic [15:0] b,
                              logic [15:0] c, logic [15:0] d);
        bw[0] = a; bw[1] = b; bw[2] = c; bw[3] = d;
        for (int k = 0; k < nw; k++) load_word(bw[k]);
    endtask

    task automatic display(string tag, bit starve, int pause_at, int md_wr);
        @(negedge clk);
        disp_en = 1'b1;
        if (md_wr >= 0) begin
            reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = 16'(md_wr);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            reg_we = 1'b0;
            chk(tag, outs(), model(bits_at(i)));
            if (i == 0)  first_o = outs();
            if (i == 15) last_o  = outs();
            if (i == pause_at) begin
                pix_en = 1'b0;
                for (int h = 0; h < 3; h++) begin
                    @(negedge clk);
                    chk("R10 hold during pause", outs(), model(bits_at(i)));
                end
                pix_en = 1'b1;
            end
        end
        if (starve) begin
            @(negedge clk);
            chk("R9 starved pixel uses index 0", outs(), model(4'd0));
        end
        disp_en = 1'b0;
        @(negedge clk);
        chk("R6 border after group", outs(), border());
        if (md_wr >= 0) mode_m = 2'(md_wr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1..R11 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", outs(), 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 border black with cleared palette", outs(), 10'd0);

        for (int i = 0; i < 16; i++) set_pal(i, 9'((i * 73 + 5)));
        @(negedge clk);
        chk("R2 R6 border field decode", outs(), {pal_m[0], 1'b0});

        // R3 table walk in 4-plane mode
        for (int t = 0; t < 4; t++) begin
            load_group(4, TBL[t][71:56], TBL[t][55:40], TBL[t][39:24], TBL[t][23:8]);
            display("R3 four-plane pixel", 1'b0, -1, -1);
            chk("R3 leftmost from bit 15", first_o, model(TBL[t][7:4]));
            chk("R3 rightmost from bit 0", last_o, model(TBL[t][3:0]));
        end

        // R10 pause mid-group
        load_group(4, TBL[1][71:56], TBL[1][55:40], TBL[1][39:24], TBL[1][23:8]);
        display("R10 resume after pause", 1'b0, 5, -1);

        // R9 run dry in 4-plane
        load_group(4, TBL[2][71:56], TBL[2][55:40], TBL[2][39:24], TBL[2][23:8]);
        display("R9 group before starve", 1'b1, -1, -1);

        // R4 two-plane
        wreg(5'd16, 16'h0001); mode_m = 2'd1;
        repeat (2) @(negedge clk);
        load_group(2, 16'hC3A5, 16'h0FF0, 16'hFFFF, 16'hFFFF);
        display("R4 two-plane pixel", 1'b1, -1, -1);

        // R7 reserved value ignored
        wreg(5'd16, 16'h0003);
        repeat (2) @(negedge clk);
        load_group(2, 16'h1E78, 16'hB44B, 16'h0, 16'h0);
        display("R7 reserved mode ignored", 1'b1, -1, -1);

        // R7 write during display waits for blanking
        load_group(2, 16'h6996, 16'hF00F, 16'h0, 16'h0);
        display("R7 mode held while displaying", 1'b0, -1, 0);
        repeat (2) @(negedge clk);
        load_group(4, TBL[3][71:56], TBL[3][55:40], TBL[3][39:24], TBL[3][23:8]);
        display("R7 mode applied in blanking", 1'b0, -1, -1);

        // R8 partial group discarded on mode change, then R5 mono
        load_word(16'hDEAD);
        wreg(5'd16, 16'h0002); mode_m = 2'd2;
        repeat (2) @(negedge clk);
        load_group(1, 16'hF0A5, 16'h0, 16'h0, 16'h0);
        display("R8 R5 mono inverted", 1'b1, -1, -1);
        set_pal(0, 9'h1A6);
        load_group(1, 16'h3C5A, 16'h0, 16'h0, 16'h0);
        display("R5 mono normal", 1'b1, -1, -1);

        // R11 surplus strobe while group waits
        wreg(5'd16, 16'h0000); mode_m = 2'd0;
        repeat (2) @(negedge clk);
        load_group(4, TBL[3][71:56], TBL[3][55:40], TBL[3][39:24], TBL[3][23:8]);
        load_word(16'h1234);
        display("R11 extra strobe dropped", 1'b1, -1, -1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule